// File: doc/BRIEF.md
# Double-Buffered Serial Configuration Loader

This block receives configuration words over a three-wire serial link made of a serial clock, a data line and a load strobe. Every line is brought into the system clock domain through a synchronizer, followed by an edge detector. Each detected rising edge of the serial clock shifts one data bit into a 32-bit word, with the most significant bit arriving first. A rising edge on the load strobe then delivers the assembled word to one of eight register slots. The three lowest bits of the word select the slot.

Some settings must change together even though they arrive in separate words. The low part of the fraction and every reference-path setting (divider, halving flag, doubler enable and charge-current code) are held first in a staging copy. A write to slot 0 carries the integer divider and the upper fraction bits. That same write copies all staged values into the active outputs in one system-clock cycle. A one-cycle update strobe marks the cycle in which the new active values appear. Software is expected to write slot 1 and slot 2 before slot 0.

Top module: `cfg_serial_loader`

## Requirements
- R1: While reset is asserted and after it is released, every active output is zero and `upd_stb` is low until the first slot-0 load.
- R2: The word is the last 32 bits shifted, most significant first. Bits 2..0 of the word select the slot (000 = slot 0 through 111 = slot 7).
- R3: A slot-0 load sets `int_div` from word bits 26..15 and `frac[24:13]` from word bits 14..3.
- R4: A slot-1 load stores word bits 15..3 in a staging copy only. `frac[12:0]` takes that value at the next slot-0 load and not before.
- R5: A slot-2 load stages `ref_div` from bits 19..15, `ref_half` from bit 20, `ref_dbl` from bit 21 and `cp_cur` from bits 27..24. None of these outputs changes until the next slot-0 load.
- R6: Every slot-0 load raises `upd_stb` for exactly one system clock, in the cycle in which the new active values first appear. No other load raises it.
- R7: Loads to slots 3 through 7 change no output.
- R8: When more than 32 bits are shifted before a load, only the last 32 are used.
- R9: Staged values persist after a commit. A later slot-0 load with no new slot-1 or slot-2 load keeps the same low fraction and reference settings.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock, asynchronous, at most a quarter of the clk rate |
| ser_dat | input | 1 | Serial data, most significant bit first |
| ser_le | input | 1 | Load strobe; its rising edge delivers the word |
| ref_div | output | 5 | Active reference divider value |
| ref_half | output | 1 | Active reference divide-by-two flag |
| ref_dbl | output | 1 | Active reference doubler enable |
| cp_cur | output | 4 | Active charge-current code |
| int_div | output | 12 | Active integer divider |
| frac | output | 25 | Active fraction, upper 12 bits from slot 0 and lower 13 from slot 1 |
| upd_stb | output | 1 | One-cycle pulse when the active settings are loaded |

## Verification
The bench stages a low fraction and a reference setup, then checks the outputs before the slot-0 load. A design without double buffering would show the new values early at that point. It sends loads to slots 3 through 7 carrying busy bit patterns, which catches a decoder that aliases them onto slots 0 to 2. It shifts extra leading bits before a word, so a shifter that keeps the first 32 bits instead of the last would be exposed. It also repeats a slot-0 load with no new staging, which catches a design that clears the staging copy on commit. A scoreboard matches each strobe pulse against the expected active values, so a missing strobe, a stray strobe or a stretched strobe is reported.

// File: rtl/cfg_loader_pkg.sv
package cfg_loader_pkg;
   // Slot numbers decoded from the low bits of a word
   localparam int SLOT_MAIN  = 0;
   localparam int SLOT_FLO   = 1;
   localparam int SLOT_REF   = 2;
   // Common start of payload above the slot field
   localparam int PAYLOAD_LSB = 3;
   // Reference-slot layout anchors
   localparam int REF_DIV_LSB = 15;
   localparam int REF_GAP     = 2;

   typedef enum logic [1:0] {
      BUF_DOUBLE = 2'd0,
      BUF_DIRECT = 2'd1
   } buf_mode_e;
endpackage

// File: rtl/cfg_edge_sync.sv
module cfg_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic level,
   output logic rise
);
   localparam int LAST = STAGES - 1;

   logic [LAST:0] chain;
   logic          level_d;

   generate
      if (STAGES < 2) begin : g_bad_depth
         $error("cfg_edge_sync: STAGES must be at least 2");
      end
   endgenerate

   genvar gi;
   generate
      for (gi = 0; gi < STAGES; gi++) begin : g_stage
         if (gi == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[gi] <= 1'b0;
               else        chain[gi] <= async_in;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) chain[gi] <= 1'b0;
               else        chain[gi] <= chain[gi-1];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) level_d <= 1'b0;
      else        level_d <= chain[LAST];
   end

   assign level = chain[LAST];
   assign rise  = chain[LAST] & ~level_d;
endmodule

// File: rtl/cfg_shift_in.sv
module cfg_shift_in #(
   parameter int WORD_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              shift_en,
   input  logic              bit_in,
   output logic [WORD_W-1:0] word
);
   generate
      if (WORD_W < 8) begin : g_bad_width
         $error("cfg_shift_in: WORD_W too small");
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        word <= '0;
      else if (shift_en) word <= {word[WORD_W-2:0], bit_in};
   end

   // R2 / R8: newest bit lands at bit 0, older bits move up, oldest falls out
   p_shift_msb_first_r2: assert property (@(posedge clk) disable iff (!rst_n)
      shift_en |=> (word[0] == $past(bit_in)) &&
                   (word[WORD_W-1:1] == $past(word[WORD_W-2:0])));
   p_hold_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !shift_en |=> $stable(word));
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
   import cfg_loader_pkg::*;
#(
   parameter int        WORD_W    = 32,
   parameter int        SLOT_W    = 3,
   parameter int        REF_W     = 5,
   parameter int        INT_W     = 12,
   parameter int        FRAC_HI_W = 12,
   parameter int        FRAC_LO_W = 13,
   parameter int        CUR_W     = 4,
   parameter buf_mode_e BUF_MODE  = BUF_DOUBLE
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic [WORD_W-1:0]             wr_word,
   output logic [REF_W-1:0]              ref_div,
   output logic                          ref_half,
   output logic                          ref_dbl,
   output logic [CUR_W-1:0]              cp_cur,
   output logic [INT_W-1:0]              int_div,
   output logic [FRAC_HI_W+FRAC_LO_W-1:0] frac,
   output logic                          upd_stb
);
   localparam int FHI_LSB  = PAYLOAD_LSB;
   localparam int INT_LSB  = FHI_LSB + FRAC_HI_W;
   localparam int FLO_LSB  = PAYLOAD_LSB;
   localparam int HALF_BIT = REF_DIV_LSB + REF_W;
   localparam int DBL_BIT  = HALF_BIT + 1;
   localparam int CUR_LSB  = DBL_BIT + 1 + REF_GAP;

   generate
      if (INT_LSB + INT_W > WORD_W) begin : g_bad_main
         $error("cfg_reg_bank: main slot fields exceed word");
      end
      if (CUR_LSB + CUR_W > WORD_W) begin : g_bad_ref
         $error("cfg_reg_bank: reference slot fields exceed word");
      end
      if (FLO_LSB + FRAC_LO_W > WORD_W) begin : g_bad_flo
         $error("cfg_reg_bank: low fraction exceeds word");
      end
   endgenerate

   logic [SLOT_W-1:0] slot;
   logic              hit_main, hit_flo, hit_ref;
   logic              unused_word;

   assign slot     = wr_word[SLOT_W-1:0];
   assign hit_main = wr_en && (slot == SLOT_W'(SLOT_MAIN));
   assign hit_flo  = wr_en && (slot == SLOT_W'(SLOT_FLO));
   assign hit_ref  = wr_en && (slot == SLOT_W'(SLOT_REF));
   assign unused_word = ^wr_word;

   // Fields decoded from the incoming word
   logic [INT_W-1:0]     in_int;
   logic [FRAC_HI_W-1:0] in_fhi;
   logic [FRAC_LO_W-1:0] in_flo;
   logic [REF_W-1:0]     in_ref;
   logic                 in_half, in_dbl;
   logic [CUR_W-1:0]     in_cur;

   assign in_int  = wr_word[INT_LSB +: INT_W];
   assign in_fhi  = wr_word[FHI_LSB +: FRAC_HI_W];
   assign in_flo  = wr_word[FLO_LSB +: FRAC_LO_W];
   assign in_ref  = wr_word[REF_DIV_LSB +: REF_W];
   assign in_half = wr_word[HALF_BIT];
   assign in_dbl  = wr_word[DBL_BIT];
   assign in_cur  = wr_word[CUR_LSB +: CUR_W];

   // Main-slot fields are always single buffered
   logic [INT_W-1:0]     act_int;
   logic [FRAC_HI_W-1:0] act_fhi;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         act_int <= '0;
         act_fhi <= '0;
      end else if (hit_main) begin
         act_int <= in_int;
         act_fhi <= in_fhi;
      end
   end

   logic [FRAC_LO_W-1:0] act_flo;
   logic [REF_W-1:0]     act_ref;
   logic                 act_half, act_dbl;
   logic [CUR_W-1:0]     act_cur;

   generate
      if (BUF_MODE == BUF_DOUBLE) begin : g_double
         logic [FRAC_LO_W-1:0] stg_flo;
         logic [REF_W-1:0]     stg_ref;
         logic                 stg_half, stg_dbl;
         logic [CUR_W-1:0]     stg_cur;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stg_flo <= '0;
            end else if (hit_flo) begin
               stg_flo <= in_flo;
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               stg_ref  <= '0;
               stg_half <= 1'b0;
               stg_dbl  <= 1'b0;
               stg_cur  <= '0;
            end else if (hit_ref) begin
               stg_ref  <= in_ref;
               stg_half <= in_half;
               stg_dbl  <= in_dbl;
               stg_cur  <= in_cur;
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               act_flo  <= '0;
               act_ref  <= '0;
               act_half <= 1'b0;
               act_dbl  <= 1'b0;
               act_cur  <= '0;
            end else if (hit_main) begin
               act_flo  <= stg_flo;
               act_ref  <= stg_ref;
               act_half <= stg_half;
               act_dbl  <= stg_dbl;
               act_cur  <= stg_cur;
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) upd_stb <= 1'b0;
            else        upd_stb <= hit_main;
         end

         // R4: low fraction moves only together with a commit strobe
         p_flo_only_on_commit_r4: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(act_flo) |-> upd_stb);
         // R5: reference settings move only together with a commit strobe
         p_ref_only_on_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable({act_ref, act_half, act_dbl, act_cur}) |-> upd_stb);
         // R9: a commit copies whatever the staging copy held
         p_commit_copies_stage_r9: assert property (@(posedge clk) disable iff (!rst_n)
            upd_stb |-> (act_flo == $past(stg_flo)) &&
                        ({act_ref, act_half, act_dbl, act_cur} ==
                         $past({stg_ref, stg_half, stg_dbl, stg_cur})));
      end else begin : g_direct
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               act_flo <= '0;
            end else if (hit_flo) begin
               act_flo <= in_flo;
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               act_ref  <= '0;
               act_half <= 1'b0;
               act_dbl  <= 1'b0;
               act_cur  <= '0;
            end else if (hit_ref) begin
               act_ref  <= in_ref;
               act_half <= in_half;
               act_dbl  <= in_dbl;
               act_cur  <= in_cur;
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) upd_stb <= 1'b0;
            else        upd_stb <= hit_main | hit_flo | hit_ref;
         end
      end
   endgenerate

   assign ref_div  = act_ref;
   assign ref_half = act_half;
   assign ref_dbl  = act_dbl;
   assign cp_cur   = act_cur;
   assign int_div  = act_int;
   assign frac     = {act_fhi, act_flo};

   // R6: the strobe lasts a single cycle
   p_strobe_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
      upd_stb |=> !upd_stb);
   // R3: main fields change only in a strobe cycle
   p_main_only_on_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable({act_int, act_fhi}) |-> upd_stb);
   // R7: a load to a slot above 2 leaves every output unchanged
   p_high_slot_no_effect_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && slot > SLOT_W'(SLOT_REF)) |=>
         $stable({ref_div, ref_half, ref_dbl, cp_cur, int_div, frac}) && !upd_stb);
endmodule

// File: rtl/cfg_serial_loader.sv
module cfg_serial_loader
   import cfg_loader_pkg::*;
#(
   parameter int        WORD_W      = 32,
   parameter int        SLOT_W      = 3,
   parameter int        SYNC_STAGES = 2,
   parameter int        REF_W       = 5,
   parameter int        INT_W       = 12,
   parameter int        FRAC_HI_W   = 12,
   parameter int        FRAC_LO_W   = 13,
   parameter int        CUR_W       = 4,
   parameter buf_mode_e BUF_MODE    = BUF_DOUBLE
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  ser_clk,
   input  logic                  ser_dat,
   input  logic                  ser_le,
   output logic [4:0]            ref_div,
   output logic                  ref_half,
   output logic                  ref_dbl,
   output logic [3:0]            cp_cur,
   output logic [11:0]           int_div,
   output logic [24:0]           frac,
   output logic                  upd_stb
);
   localparam int FRAC_W = FRAC_HI_W + FRAC_LO_W;

   generate
      if (REF_W != 5 || INT_W != 12 || FRAC_W != 25 || CUR_W != 4) begin : g_bad_ports
         $error("cfg_serial_loader: field widths must match the port widths");
      end
      if (SLOT_W != 3) begin : g_bad_slot
         $error("cfg_serial_loader: eight slots need a 3-bit selector");
      end
   endgenerate

   logic sclk_lvl, sclk_rise;
   logic dat_lvl,  dat_rise;
   logic le_lvl,   le_rise;
   logic [WORD_W-1:0] shift_word;

   cfg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_clk (
      .clk(clk), .rst_n(rst_n), .async_in(ser_clk), .level(sclk_lvl), .rise(sclk_rise));
   cfg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_dat (
      .clk(clk), .rst_n(rst_n), .async_in(ser_dat), .level(dat_lvl), .rise(dat_rise));
   cfg_edge_sync #(.STAGES(SYNC_STAGES)) u_sync_le (
      .clk(clk), .rst_n(rst_n), .async_in(ser_le), .level(le_lvl), .rise(le_rise));

   logic unused_levels;
   assign unused_levels = sclk_lvl ^ dat_rise ^ le_lvl;

   cfg_shift_in #(.WORD_W(WORD_W)) u_shift (
      .clk(clk), .rst_n(rst_n), .shift_en(sclk_rise), .bit_in(dat_lvl), .word(shift_word));

   cfg_reg_bank #(
      .WORD_W(WORD_W), .SLOT_W(SLOT_W), .REF_W(REF_W), .INT_W(INT_W),
      .FRAC_HI_W(FRAC_HI_W), .FRAC_LO_W(FRAC_LO_W), .CUR_W(CUR_W), .BUF_MODE(BUF_MODE)
   ) u_bank (
      .clk(clk), .rst_n(rst_n), .wr_en(le_rise), .wr_word(shift_word),
      .ref_div(ref_div), .ref_half(ref_half), .ref_dbl(ref_dbl), .cp_cur(cp_cur),
      .int_div(int_div), .frac(frac), .upd_stb(upd_stb));

   // R6: a strobe is always preceded by a load event
   p_strobe_from_load_r6: assert property (@(posedge clk) disable iff (!rst_n)
      upd_stb |-> $past(le_rise));
   // R2: shifting and loading never coincide at the assumed serial rate
   p_no_shift_on_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({sclk_rise, le_rise}));
endmodule

// File: tb/cfg_serial_loader_tb.sv
module cfg_serial_loader_tb;
   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic ser_clk = 1'b0, ser_dat = 1'b0, ser_le = 1'b0;
   logic [4:0]  ref_div;
   logic        ref_half, ref_dbl;
   logic [3:0]  cp_cur;
   logic [11:0] int_div;
   logic [24:0] frac;
   logic        upd_stb;

   always #5 clk = ~clk;

   cfg_serial_loader u_dut (
      .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_le(ser_le),
      .ref_div(ref_div), .ref_half(ref_half), .ref_dbl(ref_dbl), .cp_cur(cp_cur),
      .int_div(int_div), .frac(frac), .upd_stb(upd_stb));

   int tests = 0, fails = 0, strobes = 0, commits = 0;
   logic [47:0] exp_q[$];
   bit done = 0;

   // Model state built from the requirements
   logic [12:0] m_flo;
   logic [4:0]  m_ref;
   logic        m_half, m_dbl;
   logic [3:0]  m_cur;

   function automatic logic [47:0] pack_out();
      return {ref_div, ref_half, ref_dbl, cp_cur, int_div, frac};
   endfunction

   task automatic check(string req, logic [47:0] act, logic [47:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic shift_bits(logic [31:0] bits, int n);
      for (int i = n - 1; i >= 0; i--) begin
         ser_dat = bits[i];
         repeat (4) @(posedge clk);
         ser_clk = 1'b1;
         repeat (4) @(posedge clk);
         ser_clk = 1'b0;
      end
   endtask

   task automatic load_word(logic [31:0] w);
      shift_bits(w, 32);
      repeat (4) @(posedge clk);
      ser_le = 1'b1;
      repeat (6) @(posedge clk);
      ser_le = 1'b0;
      repeat (8) @(posedge clk);
   endtask

   function automatic logic [31:0] w_main(logic [11:0] iv, logic [11:0] fh);
      return {5'b0, iv, fh, 3'b000};
   endfunction
   function automatic logic [31:0] w_flo(logic [12:0] lo);
      return {16'h0, lo, 3'b001};
   endfunction
   function automatic logic [31:0] w_ref(logic [4:0] r, logic h, logic d, logic [3:0] c);
      return {4'b0, c, 2'b0, d, h, r, 12'b0, 3'b010};
   endfunction

   // Driver for slot-0 loads: pushes expected active values, then sends
   task automatic commit(logic [11:0] iv, logic [11:0] fh, logic [31:0] pre, int pre_n);
      exp_q.push_back({m_ref, m_half, m_dbl, m_cur, iv, fh, m_flo});
      commits++;
      if (pre_n > 0) shift_bits(pre, pre_n);
      load_word(w_main(iv, fh));
   endtask

   // Monitor: compares each strobe against the scoreboard queue
   logic prev_stb = 1'b0;
   initial begin
      while (!done) begin
         @(negedge clk);
         if (upd_stb) begin
            strobes++;
            if (prev_stb) check("R6 strobe width", 48'd1, 48'd0);
            else if (exp_q.size() == 0) check("R6 unexpected strobe", 48'd1, 48'd0);
            else check("R3/R4/R5 committed values", pack_out(), exp_q.pop_front());
         end
         prev_stb = upd_stb;
      end
   end

   // Watchdog
   initial begin
      repeat (150000) @(posedge clk);
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [47:0] snap;
      m_flo = '0; m_ref = '0; m_half = 0; m_dbl = 0; m_cur = '0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 outputs in reset", {pack_out()}, 48'd0);
      check("R1 strobe in reset", {47'd0, upd_stb}, 48'd0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check("R1 outputs after reset", pack_out(), 48'd0);

      // R4: stage low fraction, outputs unchanged
      load_word(w_flo(13'h1ABC));
      @(negedge clk);
      check("R4 low fraction not yet active", pack_out(), 48'd0);
      m_flo = 13'h1ABC;
      // R5: stage reference setup
      load_word(w_ref(5'h13, 1'b1, 1'b0, 4'hA));
      @(negedge clk);
      check("R5 reference not yet active", pack_out(), 48'd0);
      m_ref = 5'h13; m_half = 1; m_dbl = 0; m_cur = 4'hA;

      // R2/R3: commit
      commit(12'h5A3, 12'hBEE, 32'h0, 0);
      @(negedge clk);
      check("R2 R3 after first commit", pack_out(),
            {m_ref, m_half, m_dbl, m_cur, 12'h5A3, 12'hBEE, m_flo});

      // R7: slots 3..7 with busy patterns
      snap = pack_out();
      for (int s = 3; s < 8; s++) begin
         load_word({29'h1FFF_FFFF ^ 29'(s * 29'h0123_4567), 3'(s)});
         @(negedge clk);
         check($sformatf("R7 slot %0d ignored", s), pack_out(), snap);
      end
      check("R6 strobe count after ignored slots", 48'(strobes), 48'(commits));

      // R8: extra leading ones before a slot-0 word
      commit(12'h0F1, 12'h00C, 32'hFFFF_FFFF, 9);
      @(negedge clk);
      check("R8 last 32 bits used", {36'd0, int_div}, {36'd0, 12'h0F1});

      // R9: repeat commit without new staging
      commit(12'h777, 12'h123, 32'h0, 0);
      @(negedge clk);
      check("R9 staged values retained", pack_out(),
            {m_ref, m_half, m_dbl, m_cur, 12'h777, 12'h123, m_flo});

      // R4/R5 again with new values, including doubler and all-ones fields
      load_word(w_flo(13'h0001));
      load_word(w_ref(5'h1F, 1'b0, 1'b1, 4'hF));
      @(negedge clk);
      check("R4 R5 second staging held", pack_out(),
            {5'h13, 1'b1, 1'b0, 4'hA, 12'h777, 12'h123, 13'h1ABC});
      m_flo = 13'h0001; m_ref = 5'h1F; m_half = 0; m_dbl = 1; m_cur = 4'hF;
      commit(12'hFFF, 12'hFFF, 32'h0, 0);
      @(negedge clk);
      check("R3 R4 R5 second commit", pack_out(),
            {5'h1F, 1'b0, 1'b1, 4'hF, 12'hFFF, 12'hFFF, 13'h0001});

      repeat (10) @(negedge clk);
      check("R6 one strobe per slot-0 load", 48'(strobes), 48'(commits));
      check("R6 scoreboard drained", 48'(exp_q.size()), 48'd0);
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule